// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Tags

This block sits between an asynchronous serial deserializer and the host data port. Each received character is pushed in along with its break, framing and parity flags. The host reads data from the head of the queue. The flags travel with their own character and show only while that character is at the head. Software can therefore tell exactly which byte was damaged, even when several bytes are waiting.

After reset the block behaves as a single-byte holding register. Setting the enable bit in its control word switches it to a multi-entry queue, and the same bit is passed on so that a companion transmit queue is enabled too. The control word also carries a self-clearing receive flush and a two-bit selector for the fill level that raises a data-available request. The block also provides a sticky overrun flag and an aggregate error bit that is set while any stored character is tagged with an error.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset the block is in single-byte mode, level is 0, the control readback is 0x00, and overrun, aggregate error, request and all head outputs are 0.
- R2: In single-byte mode the capacity is one. A push while holding a byte keeps the held byte unchanged and sets overrun.
- R3: Writing control bit 0 as 1 selects queue mode with DEPTH entries, raises fifo_mode_o, and delivers bytes in push order.
- R4: A control write that changes bit 0 empties the queue.
- R5: A control write with bit 1 set empties the queue and clears all stored flags. Bit 1 reads back as 0 afterwards, while bits 7:6 and 0 read back as written.
- R6: In queue mode, control bits 7:6 values 0, 1, 2 and 3 select request levels of 1, DEPTH/4, DEPTH/2 and DEPTH-2 (1, 4, 8 and 14 for 16 entries). trig_o is 1 exactly while level is at or above the selected value. In single-byte mode the level used is 1.
- R7: head_brk_o, head_fe_o and head_pe_o show the flags pushed with the head character only. All head outputs are 0 when the queue is empty.
- R8: err_any_o is 1 while any stored character still carries a break, framing or parity flag.
- R9: A status read (stat_rd_i) clears overrun and the flags of the current head character.
- R10: A push into a full queue with no pop alters no entry and no level, and sets overrun. A push and a pop in the same cycle on a full queue are both accepted.
- R11: A pop on an empty queue has no effect. A flush in the same cycle as a push discards the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control word: bit0 queue enable, bit1 flush, bits7:6 request level |
| ctl_rdata_o | output | 8 | Control word readback |
| fifo_mode_o | output | 1 | Queue mode active (shared with transmit side) |
| push_i | input | 1 | Character push from deserializer |
| push_data_i | input | DW | Pushed character |
| push_brk_i | input | 1 | Break flag of pushed character |
| push_fe_i | input | 1 | Framing error flag of pushed character |
| push_pe_i | input | 1 | Parity error flag of pushed character |
| pop_i | input | 1 | Host data read |
| stat_rd_i | input | 1 | Host status read |
| head_data_o | output | DW | Character at head |
| head_brk_o | output | 1 | Head break flag |
| head_fe_o | output | 1 | Head framing flag |
| head_pe_o | output | 1 | Head parity flag |
| level_o | output | $clog2(DEPTH+1) | Occupancy |
| overrun_o | output | 1 | Sticky overrun |
| err_any_o | output | 1 | Some stored character has an error |
| trig_o | output | 1 | Data-available request |

## Verification
The bench queues clean and tagged characters behind one another. A design that exposed flags early, or let them slip to a neighbouring entry, would report an error on a clean head byte. It pushes into a full queue, with and without a simultaneous pop. Here an overwriting design would corrupt the tail or the head, and a rigid one would drop the push accepted alongside the pop. It sweeps all four request levels up and down by one entry each, which exposes off-by-one comparisons. It also checks that mode changes and the flush bit empty the queue while the flush bit reads back as 0.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rx_err_t;

  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'd0:    return 1;
      2'd1:    return depth / 4;
      2'd2:    return depth / 2;
      default: return depth - 2;
    endcase
  endfunction
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic       fifo_mode_o,
  output logic [1:0] trig_sel_o,
  output logic       flush_o,
  output logic [7:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_mode_o <= 1'b0;
      trig_sel_o  <= 2'd0;
    end else if (we_i) begin
      fifo_mode_o <= wdata_i[0];
      trig_sel_o  <= wdata_i[7:6];
    end
  end

  // flush bit is a strobe only; a mode change also flushes
  assign flush_o = we_i & (wdata_i[1] | (wdata_i[0] != fifo_mode_o));
  assign rdata_o = {trig_sel_o, 5'b0, fifo_mode_o};
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_mode_i,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  rx_err_t       err_i,
  input  logic          pop_i,
  input  logic          stat_rd_i,
  output logic [DW-1:0] head_data_o,
  output rx_err_t       head_err_o,
  output logic [CW-1:0] count_o,
  output logic          overrun_o,
  output logic          err_any_o
);
  logic [DW-1:0] mem_q  [DEPTH];
  rx_err_t       errs_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cap;
  logic          full, empty, do_pop, do_push, ovr_set;

  assign cap     = fifo_mode_i ? CW'(DEPTH) : CW'(1);
  assign empty   = (count_o == '0);
  assign full    = (count_o >= cap);
  assign do_pop  = pop_i & ~empty & ~flush_i;
  assign do_push = push_i & (~full | do_pop) & ~flush_i;
  assign ovr_set = push_i & full & ~do_pop & ~flush_i;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q      <= '0;
      rd_q      <= '0;
      count_o   <= '0;
      overrun_o <= 1'b0;
      for (int i = 0; i < DEPTH; i++) errs_q[i] <= '0;
    end else begin
      if (ovr_set)        overrun_o <= 1'b1;
      else if (stat_rd_i) overrun_o <= 1'b0;
      if (flush_i) begin
        wr_q    <= '0;
        rd_q    <= '0;
        count_o <= '0;
        for (int i = 0; i < DEPTH; i++) errs_q[i] <= '0;
      end else begin
        if ((stat_rd_i & ~empty) | do_pop) errs_q[rd_q] <= '0;
        if (do_pop) rd_q <= nxt(rd_q);
        if (do_push) begin
          wr_q         <= nxt(wr_q);
          errs_q[wr_q] <= err_i;  // later assignment wins on slot reuse
        end
        count_o <= count_o + CW'(do_push) - CW'(do_pop);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_comb begin
    err_any_o = 1'b0;
    for (int i = 0; i < DEPTH; i++) err_any_o |= |errs_q[i];
  end

  assign head_data_o = empty ? '0 : mem_q[rd_q];
  assign head_err_o  = empty ? '0 : errs_q[rd_q];

  a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= cap);
  a_r10_full_push_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !flush_i && fifo_mode_i) |=> (count_o == $past(count_o)) && overrun_o);
  a_r5_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_o == '0) && !err_any_o);
  a_r11_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty && !push_i) |=> count_o == '0);
endmodule

// File: rtl/rxq_thresh.sv
module rxq_thresh
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          fifo_mode_i,
  input  logic [1:0]    sel_i,
  input  logic [CW-1:0] count_i,
  output logic          trig_o
);
  logic [CW-1:0] lvl;
  assign lvl    = fifo_mode_i ? CW'(trig_level(sel_i, DEPTH)) : CW'(1);
  assign trig_o = (count_i >= lvl);
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import rxq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctl_we_i,
  input  logic [7:0]    ctl_wdata_i,
  output logic [7:0]    ctl_rdata_o,
  output logic          fifo_mode_o,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          push_brk_i,
  input  logic          push_fe_i,
  input  logic          push_pe_i,
  input  logic          pop_i,
  input  logic          stat_rd_i,
  output logic [DW-1:0] head_data_o,
  output logic          head_brk_o,
  output logic          head_fe_o,
  output logic          head_pe_o,
  output logic [CW-1:0] level_o,
  output logic          overrun_o,
  output logic          err_any_o,
  output logic          trig_o
);
  logic       flush;
  logic [1:0] trig_sel;
  rx_err_t    in_err, head_err;

  assign in_err = '{brk: push_brk_i, fe: push_fe_i, pe: push_pe_i};

  rxq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (ctl_we_i),
    .wdata_i     (ctl_wdata_i),
    .fifo_mode_o (fifo_mode_o),
    .trig_sel_o  (trig_sel),
    .flush_o     (flush),
    .rdata_o     (ctl_rdata_o)
  );

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fifo_mode_i (fifo_mode_o),
    .flush_i     (flush),
    .push_i      (push_i),
    .data_i      (push_data_i),
    .err_i       (in_err),
    .pop_i       (pop_i),
    .stat_rd_i   (stat_rd_i),
    .head_data_o (head_data_o),
    .head_err_o  (head_err),
    .count_o     (level_o),
    .overrun_o   (overrun_o),
    .err_any_o   (err_any_o)
  );

  rxq_thresh #(.DEPTH(DEPTH)) u_thresh (
    .fifo_mode_i (fifo_mode_o),
    .sel_i       (trig_sel),
    .count_i     (level_o),
    .trig_o      (trig_o)
  );

  assign head_brk_o = head_err.brk;
  assign head_fe_o  = head_err.fe;
  assign head_pe_o  = head_err.pe;

  a_r6_req_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> level_o != '0);
  a_r4_mode_change_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_we_i && (ctl_wdata_i[0] != fifo_mode_o)) |=> level_o == '0);
endmodule

// File: tb/rx_tag_fifo_bench.sv
module rx_tag_fifo_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       fifo_mode;
  logic       push = 1'b0;
  logic [7:0] push_data = '0;
  logic       push_brk = 1'b0, push_fe = 1'b0, push_pe = 1'b0;
  logic       pop = 1'b0, stat_rd = 1'b0;
  logic [7:0] head_data;
  logic       head_brk, head_fe, head_pe;
  logic [4:0] level;
  logic       overrun, err_any, trig;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rx_tag_fifo u_rx_tag_fifo (
    .clk_i(clk), .rst_ni(rst_n),
    .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
    .fifo_mode_o(fifo_mode),
    .push_i(push), .push_data_i(push_data),
    .push_brk_i(push_brk), .push_fe_i(push_fe), .push_pe_i(push_pe),
    .pop_i(pop), .stat_rd_i(stat_rd),
    .head_data_o(head_data), .head_brk_o(head_brk), .head_fe_o(head_fe), .head_pe_o(head_pe),
    .level_o(level), .overrun_o(overrun), .err_any_o(err_any), .trig_o(trig)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    ctl_we = 0; push = 0; pop = 0; stat_rd = 0;
    push_brk = 0; push_fe = 0; push_pe = 0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    ctl_we = 1; ctl_wdata = v; step();
  endtask

  task automatic do_push(input logic [7:0] d, input logic [2:0] e);
    push = 1; push_data = d; {push_brk, push_fe, push_pe} = e; step();
  endtask

  task automatic do_pop();
    pop = 1; step();
  endtask

  task automatic t_reset();
    chk("R1 mode", fifo_mode, 0);
    chk("R1 level", level, 0);
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 flags", {overrun, err_any, trig, head_brk, head_fe, head_pe}, 0);
    chk("R1 head", head_data, 0);
  endtask

  task automatic t_char_mode();
    do_push(8'hA5, 3'b000);
    chk("R2 held", head_data, 8'hA5);
    chk("R6 char trig", trig, 1);
    do_push(8'h3C, 3'b000);
    chk("R2 keep", head_data, 8'hA5);
    chk("R2 level", level, 1);
    chk("R2 overrun", overrun, 1);
    stat_rd = 1; step();
    chk("R9 ovr clear", overrun, 0);
    do_pop();
    chk("R7 empty head", {head_data, head_brk, head_fe, head_pe}, 0);
    chk("R6 char trig off", trig, 0);
  endtask

  task automatic t_fifo_order();
    wr_ctl(8'h01);
    chk("R3 mode", fifo_mode, 1);
    for (int i = 0; i < 16; i++) do_push(8'(i * 3 + 1), 3'b000);
    chk("R3 level", level, 16);
    chk("R10 no ovr yet", overrun, 0);
    do_push(8'hEE, 3'b000);
    chk("R10 level held", level, 16);
    chk("R10 overrun", overrun, 1);
    chk("R10 head kept", head_data, 8'd1);
    push = 1; push_data = 8'h77; pop = 1; step();
    chk("R10 both level", level, 16);
    chk("R3 order", head_data, 8'd4);
    for (int i = 1; i < 16; i++) begin
      chk("R3 order", head_data, 8'(i * 3 + 1));
      do_pop();
    end
    chk("R10 tail", head_data, 8'h77);
    do_push(8'h11, 3'b000);
    wr_ctl(8'h03);
    chk("R5 flush", level, 0);
    chk("R5 selfclear", ctl_rdata, 8'h01);
    stat_rd = 1; step();
  endtask

  task automatic t_trigger();
    int lv[4] = '{1, 4, 8, 14};
    for (int s = 0; s < 4; s++) begin
      wr_ctl({2'(s), 6'b000011});
      chk("R5 readback", ctl_rdata, {2'(s), 6'b000001});
      for (int k = 0; k < lv[s] - 1; k++) do_push(8'(k), 3'b000);
      chk("R6 below", trig, 0);
      do_push(8'hF0, 3'b000);
      chk("R6 at", trig, 1);
      do_pop();
      chk("R6 drop", trig, 0);
    end
    wr_ctl(8'h03);
  endtask

  task automatic t_flags();
    do_push(8'h10, 3'b000);
    do_push(8'h20, 3'b010);
    do_push(8'h30, 3'b100);
    chk("R7 clean head", {head_brk, head_fe, head_pe}, 3'b000);
    chk("R8 any", err_any, 1);
    do_pop();
    chk("R7 fe head", {head_data, head_brk, head_fe, head_pe}, {8'h20, 3'b010});
    stat_rd = 1; step();
    chk("R9 head cleared", {head_brk, head_fe, head_pe}, 3'b000);
    chk("R8 still", err_any, 1);
    do_pop();
    chk("R7 brk head", {head_data, head_brk, head_fe, head_pe}, {8'h30, 3'b100});
    do_pop();
    chk("R8 none", err_any, 0);
    do_push(8'h40, 3'b001);
    wr_ctl(8'h03);
    chk("R5 flags flushed", {err_any, level}, 0);
  endtask

  task automatic t_mode_switch();
    do_push(8'h55, 3'b000);
    do_push(8'h66, 3'b000);
    wr_ctl(8'h00);
    chk("R4 flush", level, 0);
    chk("R4 mode", fifo_mode, 0);
  endtask

  task automatic t_corner();
    do_pop();
    chk("R11 pop empty", level, 0);
    push = 1; push_data = 8'h99; ctl_we = 1; ctl_wdata = 8'h02; step();
    chk("R11 flush wins", level, 0);
    chk("R11 head", head_data, 0);
  endtask

  initial begin
    #25 rst_n = 1'b1;
    #6;
    t_reset();
    t_char_mode();
    t_fifo_order();
    t_trigger();
    t_flags();
    t_mode_switch();
    t_corner();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule